// File: doc/BRIEF.md
# Delayed-Reply Polling Read Responder

This block answers host polling reads aimed at the head of a receive completion queue. If the head entry is valid when a read is taken up, the block replies with that 64-byte entry straight away. If it is not valid, the read is parked for a programmable number of cycles. A completion that turns valid during the wait ends it at once and is returned. If the wait runs out first, the reply is an all-zero entry, so its valid flag is clear. Parking a poll in this way shortens the expected time to notify the host and cuts the number of empty replies sent back.

Reads have no side effects. Serving a read, even a repeated or speculative one, never moves the queue head. The head advances only when the host sends an explicit consumption notice. The block serves one read at a time. A further read that arrives meanwhile waits in a small in-order request queue. The block also counts three outcomes: immediate hits, hits during a hold, and timeouts.

The state machine has three states. ST_IDLE waits for a queued read. ST_HOLD is the timed wait. ST_RESP presents the reply until the host takes it. The transitions are:
- ST_IDLE→ST_RESP on an immediate hit, or on a zero delay with no valid entry.
- ST_IDLE→ST_HOLD when no entry is valid and the delay is nonzero.
- ST_HOLD→ST_RESP on a hit during the hold, or on timer expiry.
- ST_RESP→ST_IDLE when the reply handshake completes.

Top module: `poll_hold_responder`

## Requirements
- R1: After reset, rsp_valid and cq_pop are 0, rd_req_ready is 1, all three counters are 0, and the delay register holds DEF_DELAY (2000 cycles).
- R2: If bit VLD_POS (bit 0) of cq_head_entry is 1 when a queued read is taken up, rsp_valid rises one cycle after the request is accepted. The reply carries that entry unchanged, together with the request's tag.
- R3: If the head entry is not valid and the delay is D>0, the reply appears D+1 cycles after acceptance as an all-zero entry (valid bit clear).
- R4: If the head entry turns valid while a read is held, rsp_valid rises on the next cycle, carrying that entry.
- R5: With a delay of 0 and no valid entry, an all-zero reply appears one cycle after acceptance.
- R6: A configuration write with a value above MAX_DELAY (10000) stores MAX_DELAY, so the hold is bounded at 10000 cycles.
- R7: cq_pop equals cons_valid in every cycle. Serving a read never pulses cq_pop.
- R8: Reads are served one at a time and in arrival order. Up to REQ_DEPTH (2) reads can be queued, and rd_req_ready is 0 while the queue is full.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_entry and rsp_tag hold steady.
- R10: cnt_hit_now, cnt_hit_held and cnt_timeout each count one per reply of their kind (immediate hit, hit during hold, timeout or zero-delay miss).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | input | 1 | Host polling read request |
| rd_req_ready | output | 1 | Request queue can accept |
| rd_req_tag | input | TAG_W | Tag of the request |
| rsp_valid | output | 1 | Reply available |
| rsp_ready | input | 1 | Host takes reply |
| rsp_tag | output | TAG_W | Tag of the request being answered |
| rsp_entry | output | ENTRY_W | Reply entry; bit VLD_POS is the valid flag |
| cq_head_entry | input | ENTRY_W | Current queue head entry; bit VLD_POS marks it valid |
| cons_valid | input | 1 | Host consumption notice |
| cq_pop | output | 1 | Advance queue head |
| cfg_wr | input | 1 | Delay register write strobe |
| cfg_delay | input | DLY_W | Delay in cycles to write |
| cnt_hit_now | output | CNT_W | Immediate hit count |
| cnt_hit_held | output | CNT_W | Hit-during-hold count |
| cnt_timeout | output | CNT_W | Timeout count |

## Verification
The assertions assume that the device side keeps cq_head_entry steady while a reply is pending and changes it only by popping or by a new completion turning valid. They also assume that the host never asserts rd_req_valid while rd_req_ready is low. The bench drives requests only after it has seen ready, or deliberately checks that ready is low without pushing. It alters the head entry only between scenarios or at the single point where a hit during a hold is provoked. It writes the delay only while the block is idle.

// File: rtl/poll_resp_pkg.sv
`timescale 1ns/1ps
package poll_resp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_RESP = 2'd2
    } poll_state_e;

    localparam int EV_NOW   = 0;
    localparam int EV_HELD  = 1;
    localparam int EV_TMO   = 2;
    localparam int EV_COUNT = 3;

endpackage

// File: rtl/prr_req_fifo.sv
`timescale 1ns/1ps
module prr_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;

    assign empty = (fill == '0);
    assign full  = (fill == CW'(DEPTH));
    assign dout  = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (push && !pop) begin
                fill <= fill + CW'(1);
            end else if (pop && !push) begin
                fill <= fill - CW'(1);
            end
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/prr_delay_cfg.sv
`timescale 1ns/1ps
module prr_delay_cfg #(
    parameter int DLY_W     = 16,
    parameter int MAX_DELAY = 10000,
    parameter int DEF_DELAY = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DLY_W-1:0] wdata,
    output logic [DLY_W-1:0] q
);
    localparam logic [DLY_W-1:0] CAP  = DLY_W'(MAX_DELAY);
    localparam logic [DLY_W-1:0] INIT = DLY_W'(DEF_DELAY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (wr) begin
            q <= (wdata > CAP) ? CAP : wdata;
        end
    end

    // R6
    dly_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q <= CAP);

endmodule

// File: rtl/prr_hold_timer.sv
`timescale 1ns/1ps
module prr_hold_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [DLY_W-1:0] remain;

    assign expired = run && (remain == DLY_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (run && remain != '0) begin
            remain <= remain - DLY_W'(1);
        end
    end

    // R3
    timer_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |-> (remain != '0));

endmodule

// File: rtl/prr_event_ctr.sv
`timescale 1ns/1ps
module prr_event_ctr #(
    parameter int N     = 3,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       inc,
    output logic [N*CNT_W-1:0] counts
);
    for (genvar i = 0; i < N; i++) begin : g_ctr
        logic [CNT_W-1:0] c;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c <= '0;
            end else if (inc[i]) begin
                c <= c + CNT_W'(1);
            end
        end
        assign counts[i*CNT_W +: CNT_W] = c;
    end

    // R10
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc));

endmodule

// File: rtl/poll_hold_responder.sv
`timescale 1ns/1ps
module poll_hold_responder
    import poll_resp_pkg::*;
#(
    parameter int ENTRY_W   = 512,
    parameter int VLD_POS   = 0,
    parameter int TAG_W     = 8,
    parameter int DLY_W     = 16,
    parameter int MAX_DELAY = 10000,
    parameter int DEF_DELAY = 2000,
    parameter int REQ_DEPTH = 2,
    parameter int CNT_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_req_valid,
    output logic               rd_req_ready,
    input  logic [TAG_W-1:0]   rd_req_tag,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [TAG_W-1:0]   rsp_tag,
    output logic [ENTRY_W-1:0] rsp_entry,
    input  logic [ENTRY_W-1:0] cq_head_entry,
    input  logic               cons_valid,
    output logic               cq_pop,
    input  logic               cfg_wr,
    input  logic [DLY_W-1:0]   cfg_delay,
    output logic [CNT_W-1:0]   cnt_hit_now,
    output logic [CNT_W-1:0]   cnt_hit_held,
    output logic [CNT_W-1:0]   cnt_timeout
);
    localparam int ALL_CNT_W = EV_COUNT * CNT_W;

    poll_state_e state_q, state_d;

    logic               fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [TAG_W-1:0]   fifo_tag;
    logic [DLY_W-1:0]   delay_q;
    logic               tmr_load, tmr_expired;
    logic               take_entry, take_zero;
    logic [EV_COUNT-1:0] ev_inc;
    logic [ALL_CNT_W-1:0] all_counts;
    logic [ENTRY_W-1:0] entry_q;
    logic               head_ok;

    assign head_ok = cq_head_entry[VLD_POS];

    prr_req_fifo #(.W(TAG_W), .DEPTH(REQ_DEPTH)) u_req_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (rd_req_tag),
        .pop   (fifo_pop),
        .dout  (fifo_tag),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    prr_delay_cfg #(.DLY_W(DLY_W), .MAX_DELAY(MAX_DELAY), .DEF_DELAY(DEF_DELAY)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_delay),
        .q     (delay_q)
    );

    prr_hold_timer #(.DLY_W(DLY_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (delay_q),
        .run      (state_q == ST_HOLD),
        .expired  (tmr_expired)
    );

    prr_event_ctr #(.N(EV_COUNT), .CNT_W(CNT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (ev_inc),
        .counts (all_counts)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and decision strobes
    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        take_entry = 1'b0;
        take_zero  = 1'b0;
        ev_inc     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (!fifo_empty) begin
                    if (head_ok) begin
                        state_d        = ST_RESP;
                        take_entry     = 1'b1;
                        ev_inc[EV_NOW] = 1'b1;
                    end else if (delay_q == '0) begin
                        state_d        = ST_RESP;
                        take_zero      = 1'b1;
                        ev_inc[EV_TMO] = 1'b1;
                    end else begin
                        state_d  = ST_HOLD;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (head_ok) begin
                    state_d         = ST_RESP;
                    take_entry      = 1'b1;
                    ev_inc[EV_HELD] = 1'b1;
                end else if (tmr_expired) begin
                    state_d        = ST_RESP;
                    take_zero      = 1'b1;
                    ev_inc[EV_TMO] = 1'b1;
                end
            end
            ST_RESP: begin
                if (rsp_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Reply entry capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '0;
        end else if (take_entry) begin
            entry_q <= cq_head_entry;
        end else if (take_zero) begin
            entry_q <= '0;
        end
    end

    // Outputs
    always_comb begin
        rd_req_ready = !fifo_full;
        fifo_push    = rd_req_valid && !fifo_full;
        rsp_valid    = (state_q == ST_RESP);
        rsp_tag      = fifo_tag;
        rsp_entry    = entry_q;
        fifo_pop     = rsp_valid && rsp_ready;
        cq_pop       = cons_valid;
        cnt_hit_now  = all_counts[EV_NOW*CNT_W  +: CNT_W];
        cnt_hit_held = all_counts[EV_HELD*CNT_W +: CNT_W];
        cnt_timeout  = all_counts[EV_TMO*CNT_W  +: CNT_W];
    end

    // R2
    imm_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !fifo_empty && head_ok)
            |=> (rsp_valid && rsp_entry[VLD_POS]));

    // R4
    held_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && head_ok)
            |=> (rsp_valid && rsp_entry == $past(cq_head_entry)));

    // R3
    miss_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_entry[VLD_POS]) |-> (rsp_entry == '0));

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready)
            |=> (rsp_valid && $stable(rsp_entry) && $stable(rsp_tag)));

endmodule

// File: tb/poll_hold_responder_tb.sv
`timescale 1ns/1ps
module poll_hold_responder_tb;
    localparam int ENTRY_W = 512;
    localparam int TAG_W   = 8;
    localparam int DLY_W   = 16;
    localparam int CNT_W   = 16;
    localparam int MAXD    = 10000;
    localparam int DEFD    = 2000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               rd_req_valid;
    logic               rd_req_ready;
    logic [TAG_W-1:0]   rd_req_tag;
    logic               rsp_valid;
    logic               rsp_ready;
    logic [TAG_W-1:0]   rsp_tag;
    logic [ENTRY_W-1:0] rsp_entry;
    logic [ENTRY_W-1:0] cq_head_entry;
    logic               cons_valid;
    logic               cq_pop;
    logic               cfg_wr;
    logic [DLY_W-1:0]   cfg_delay;
    logic [CNT_W-1:0]   cnt_hit_now, cnt_hit_held, cnt_timeout;

    int checks   = 0;
    int failures = 0;
    int pop_mismatch = 0;

    localparam logic [ENTRY_W-1:0] ENT_A = {16{32'hA5C30F01}};
    localparam logic [ENTRY_W-1:0] ENT_B = {16{32'h5A3CF0E3}};

    always #2 clk = ~clk;

    poll_hold_responder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_tag   (rd_req_tag),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready),
        .rsp_tag      (rsp_tag),
        .rsp_entry    (rsp_entry),
        .cq_head_entry(cq_head_entry),
        .cons_valid   (cons_valid),
        .cq_pop       (cq_pop),
        .cfg_wr       (cfg_wr),
        .cfg_delay    (cfg_delay),
        .cnt_hit_now  (cnt_hit_now),
        .cnt_hit_held (cnt_hit_held),
        .cnt_timeout  (cnt_timeout)
    );

    // R7 monitor: head pop must mirror the consumption notice every cycle
    always @(negedge clk) begin
        if (rst_n === 1'b1 && cq_pop !== cons_valid) pop_mismatch++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_delay(input logic [DLY_W-1:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_delay = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Issue one read, return cycles from acceptance edge to rsp_valid
    task automatic read_wait(input logic [TAG_W-1:0] tag, output int n);
        @(negedge clk);
        rd_req_valid = 1'b1;
        rd_req_tag = tag;
        @(posedge clk);
        #1 rd_req_valid = 1'b0;
        n = 0;
        while (n < 20000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (rsp_valid) break;
        end
    endtask

    task automatic finish_rsp();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 0);
        chk(rd_req_ready == 1'b1, "R1", "rd_req_ready", 64'(rd_req_ready), 1);
        chk(cq_pop == 1'b0, "R1", "cq_pop", 64'(cq_pop), 0);
        chk(cnt_hit_now == 0 && cnt_hit_held == 0 && cnt_timeout == 0, "R1", "counters",
            64'({cnt_hit_now, cnt_hit_held, cnt_timeout}), 0);
    endtask

    task automatic t_default_timeout();
        int n;
        cq_head_entry = '0;
        read_wait(8'h11, n);
        chk(n == DEFD + 1, "R1", "default delay latency", 64'(n), 64'(DEFD + 1));
        chk(rsp_entry == '0, "R3", "timeout entry zero", rsp_entry[63:0], 0);
        chk(rsp_tag == 8'h11, "R3", "timeout tag", 64'(rsp_tag), 64'h11);
        finish_rsp();
    endtask

    task automatic t_immediate();
        int n;
        set_delay(16'd20);
        cq_head_entry = ENT_A;
        read_wait(8'h22, n);
        chk(n == 1, "R2", "immediate latency", 64'(n), 1);
        chk(rsp_entry == ENT_A, "R2", "immediate entry", rsp_entry[63:0], ENT_A[63:0]);
        chk(rsp_tag == 8'h22, "R2", "immediate tag", 64'(rsp_tag), 64'h22);
        chk(cq_pop == 1'b0, "R7", "no pop on read", 64'(cq_pop), 0);
        finish_rsp();
        cq_head_entry = '0;
    endtask

    task automatic t_hold_hit();
        cq_head_entry = '0;
        @(negedge clk);
        rd_req_valid = 1'b1;
        rd_req_tag = 8'h33;
        @(posedge clk);
        #1 rd_req_valid = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R4", "still held", 64'(rsp_valid), 0);
        cq_head_entry = ENT_B;
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R4", "reply next cycle", 64'(rsp_valid), 1);
        chk(rsp_entry == ENT_B, "R4", "held hit entry", rsp_entry[63:0], ENT_B[63:0]);
        finish_rsp();
        chk(cq_pop == 1'b0, "R7", "no pop after reply", 64'(cq_pop), 0);
        cons_valid = 1'b1;
        #0;
        #1 chk(cq_pop == 1'b1, "R7", "pop on consume", 64'(cq_pop), 1);
        @(negedge clk);
        cons_valid = 1'b0;
        cq_head_entry = '0;
    endtask

    task automatic t_timeout_short();
        int n;
        read_wait(8'h44, n);
        chk(n == 21, "R3", "hold of 20 latency", 64'(n), 21);
        chk(rsp_entry[0] == 1'b0 && rsp_entry == '0, "R3", "invalid entry", rsp_entry[63:0], 0);
        finish_rsp();
    endtask

    task automatic t_zero_delay();
        int n;
        set_delay(16'd0);
        read_wait(8'h55, n);
        chk(n == 1, "R5", "zero delay latency", 64'(n), 1);
        chk(rsp_entry == '0, "R5", "zero delay entry", rsp_entry[63:0], 0);
        finish_rsp();
    endtask

    task automatic t_clamp();
        int n;
        set_delay(16'hFFFF);
        read_wait(8'h66, n);
        chk(n == MAXD + 1, "R6", "clamped hold latency", 64'(n), 64'(MAXD + 1));
        finish_rsp();
    endtask

    task automatic t_queue();
        set_delay(16'd20);
        cq_head_entry = ENT_A;
        rsp_ready = 1'b0;
        @(negedge clk);
        rd_req_valid = 1'b1;
        rd_req_tag = 8'hA1;
        @(negedge clk);
        rd_req_tag = 8'hB2;
        @(negedge clk);
        rd_req_valid = 1'b0;
        chk(rd_req_ready == 1'b0, "R8", "ready low when full", 64'(rd_req_ready), 0);
        chk(rsp_valid == 1'b1 && rsp_tag == 8'hA1, "R8", "first tag served", 64'(rsp_tag), 64'hA1);
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b1 && rsp_tag == 8'hA1 && rsp_entry == ENT_A, "R9",
            "stable under backpressure", 64'(rsp_tag), 64'hA1);
        rsp_ready = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8", "one at a time", 64'(rsp_valid), 0);
        @(negedge clk);
        chk(rsp_valid == 1'b1 && rsp_tag == 8'hB2, "R8", "second tag in order", 64'(rsp_tag), 64'hB2);
        chk(rd_req_ready == 1'b1, "R8", "ready after drain", 64'(rd_req_ready), 1);
        finish_rsp();
        cq_head_entry = '0;
    endtask

    task automatic t_counters();
        chk(cnt_hit_now == 3, "R10", "immediate count", 64'(cnt_hit_now), 3);
        chk(cnt_hit_held == 1, "R10", "held count", 64'(cnt_hit_held), 1);
        chk(cnt_timeout == 4, "R10", "timeout count", 64'(cnt_timeout), 4);
        chk(pop_mismatch == 0, "R7", "pop mirrors consume", 64'(pop_mismatch), 0);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        rd_req_valid = 1'b0;
        rd_req_tag = '0;
        rsp_ready = 1'b1;
        cq_head_entry = '0;
        cons_valid = 1'b0;
        cfg_wr = 1'b0;
        cfg_delay = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_timeout();
        t_immediate();
        t_hold_hit();
        t_timeout_short();
        t_zero_delay();
        t_clamp();
        t_queue();
        t_counters();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule